// File: doc/BRIEF.md
# Dual-core low-power state sequencer

This block decides, for each core of a two-core processor cluster, which low-power state the core enters when it stops in standby, and it sequences the clock, power, retention and reset controls on the way down and back up. Software writes a 2-bit target state and a clock-transition mode per core before the core executes its wait-for-interrupt. The block holds that target for the whole stay in the low-power state. Deeper states are entered only in hardware-auto mode, and only when the shared cache is idle and the sibling core is also waiting for interrupt. The full-off state is the exception: it does not depend on the sibling and is available on core 1 only.

Going down, the core clock enable is dropped one cycle before any power or retention control moves. Coming back, only the external wake input is accepted. The sequencer restores power, waits a fixed settle count, re-enables the clock, and releases the core reset if the core was fully off. Only then does it report the core as ON. A shared pair check raises an error flag whenever the two cores' reported states form a combination that the coherency rules forbid.

Top module: `lp_cluster_ctrl`

## Requirements
- R1: Target codes per core are 0 ON, 1 INACT, 2 RETENTION, 3 FORCED_OFF. The reported-state codes are 0 ON, 1 INACT, 2 RETENTION, 3 OFF. Clock mode code 2 is hardware-auto, and every other code means no automatic sleep. Core x uses bits [2x+1:2x] of each 2-bit-per-core bus.
- R2: A core in wait-for-interrupt outside hardware-auto mode keeps logic and both L1 supplies on, reports ON and is not busy. Its clock enable is low for as long as its standby input is high.
- R3: A core in wait-for-event has its clock enable low and reports ON with all supplies on, whatever its target and mode.
- R4: INACT and RETENTION are entered only when all of these hold: the core is in wait-for-interrupt, its mode is hardware-auto, the shared cache is idle and the sibling core is in wait-for-interrupt. Otherwise the core stays ON with its clock stopped.
- R5: FORCED_OFF is entered by core 1 in hardware-auto mode regardless of the sibling. On core 0 the code is treated as ON, so core 0 never reports OFF.
- R6: In the low-power state, INACT keeps every supply on. RETENTION drops logic power, asserts logic retention, keeps the L1 arrays powered and turns the L1 periphery off. FORCED_OFF turns all supplies off. In every case the clock enable stays low.
- R7: Entry takes three cycles from the edge that samples the request. In the first cycle the clock is gated and the core is busy. In the second the power controls change. In the third the low-power state is reported and busy drops.
- R8: The target is latched at entry. Target or mode changes made while in a low-power state have no effect, including on the wake sequence, and a core never passes from one low-power state to another without reporting ON in between.
- R9: Dropping the standby input does not end a low-power state; only the core's wake input does.
- R10: For a wake sampled at edge E, supplies are restored after E, the clock enable returns after edge E+1+SETTLE_CYC, and ON is reported (busy low) after edge E+2+SETTLE_CYC. Busy is high throughout the wake. No reset is asserted when waking from INACT or RETENTION.
- R11: Core reset is asserted from the power-down cycle of FORCED_OFF through the clock-on cycle of its wake. It is released one cycle later, and ON is reported one cycle after that.
- R12: The pair error output is registered. One cycle after both cores are not busy and report a forbidden pair, it reads 1. The allowed pairs are: equal states among ON, INACT and RETENTION, or core 1 OFF with core 0 in any of those three.
- R13: After reset both cores report ON, have the clock enabled and all supplies on, are not busy and have reset released. The pair error reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wfi_i | input | 2 | Wait-for-interrupt standby per core |
| wfe_i | input | 2 | Wait-for-event standby per core |
| tgt_i | input | 4 | Software target state, 2 bits per core |
| clkmode_i | input | 4 | Clock-transition mode, 2 bits per core |
| l2_idle_i | input | 1 | Shared cache idle |
| wake_i | input | 2 | External wake event per core |
| clk_en_o | output | 2 | Core clock enable |
| logic_pwr_o | output | 2 | Core logic supply on |
| logic_ret_o | output | 2 | Core logic retention |
| l1_arr_pwr_o | output | 2 | L1 array supply on |
| l1_periph_pwr_o | output | 2 | L1 periphery supply on |
| core_rst_o | output | 2 | Core reset |
| pwr_state_o | output | 4 | Reported state, 2 bits per core |
| busy_o | output | 2 | Transition in progress |
| pair_err_o | output | 1 | Forbidden core-state pair |

## Verification
The assertions assume that the target and mode fields are stable from the cycle that the standby input is sampled until entry is decided. They also assume that a wake is requested only while a core sits in a low-power state, and that a core's standby input is low by the time its wake sequence reports ON. The stimulus changes targets and modes only at cycle boundaries while the core is running, or deliberately while it is parked in a low-power state. It pulses wake for exactly one cycle, and it drops standby together with or before the wake pulse, so that no core re-enters a low-power state as soon as it reports ON.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    TGT_ON    = 2'd0,
    TGT_INACT = 2'd1,
    TGT_RET   = 2'd2,
    TGT_OFF   = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    RPT_ON    = 2'd0,
    RPT_INACT = 2'd1,
    RPT_RET   = 2'd2,
    RPT_OFF   = 2'd3
  } rpt_e;

  localparam logic [1:0] CM_HW_AUTO = 2'd2;

  typedef enum logic [2:0] {
    S_RUN, S_GATE, S_DOWN, S_LP, S_UP, S_SETTLE, S_CLKON, S_RSTREL
  } seq_e;

  function automatic rpt_e to_rpt(tgt_e t);
    case (t)
      TGT_INACT: return RPT_INACT;
      TGT_RET:   return RPT_RET;
      TGT_OFF:   return RPT_OFF;
      default:   return RPT_ON;
    endcase
  endfunction
endpackage

// File: rtl/lp_settle_cnt.sv
module lp_settle_cnt #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/core_lp_seq.sv
module core_lp_seq
  import lp_pkg::*;
#(
  parameter int unsigned CORE_ID    = 0,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic [1:0] tgt_i,
  input  logic [1:0] clkmode_i,
  input  logic       peer_ok_i,
  input  logic       wake_i,
  output logic       clk_en_o,
  output logic       logic_pwr_o,
  output logic       logic_ret_o,
  output logic       l1_arr_pwr_o,
  output logic       l1_periph_pwr_o,
  output logic       core_rst_o,
  output logic [1:0] pwr_state_o,
  output logic       busy_o
);
  seq_e state_q, state_d;
  tgt_e tgt_q, tgt_d, req;
  logic off_allow, hw_auto, deep_go, need_rst, settle_done;

  // only the second core may be switched fully off
  generate
    if (CORE_ID == 1) begin : g_off_capable
      assign off_allow = 1'b1;
    end else begin : g_no_off
      assign off_allow = 1'b0;
    end
  endgenerate

  assign req      = tgt_e'(tgt_i);
  assign hw_auto  = (clkmode_i == CM_HW_AUTO);
  assign need_rst = (tgt_q == TGT_OFF);

  always_comb begin
    case (req)
      TGT_INACT, TGT_RET: deep_go = peer_ok_i;
      TGT_OFF:            deep_go = off_allow;
      default:            deep_go = 1'b0;
    endcase
    deep_go = deep_go && hw_auto && wfi_i;
  end

  lp_settle_cnt #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == S_SETTLE),
    .done_o (settle_done)
  );

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    case (state_q)
      S_RUN: if (deep_go) begin
        state_d = S_GATE;
        tgt_d   = req;
      end
      S_GATE:   state_d = S_DOWN;
      S_DOWN:   state_d = S_LP;
      S_LP:     if (wake_i) state_d = S_UP;
      S_UP:     state_d = S_SETTLE;
      S_SETTLE: if (settle_done) state_d = S_CLKON;
      S_CLKON:  state_d = need_rst ? S_RSTREL : S_RUN;
      S_RSTREL: state_d = S_RUN;
      default:  state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RUN;
      tgt_q   <= TGT_ON;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

  always_comb begin
    clk_en_o        = 1'b0;
    logic_pwr_o     = 1'b1;
    logic_ret_o     = 1'b0;
    l1_arr_pwr_o    = 1'b1;
    l1_periph_pwr_o = 1'b1;
    core_rst_o      = 1'b0;
    pwr_state_o     = RPT_ON;
    busy_o          = 1'b1;
    case (state_q)
      S_RUN: begin
        clk_en_o = !(wfi_i || wfe_i);
        busy_o   = 1'b0;
      end
      S_DOWN, S_LP: begin
        case (tgt_q)
          TGT_RET: begin
            logic_pwr_o     = 1'b0;
            logic_ret_o     = 1'b1;
            l1_periph_pwr_o = 1'b0;
          end
          TGT_OFF: begin
            logic_pwr_o     = 1'b0;
            l1_arr_pwr_o    = 1'b0;
            l1_periph_pwr_o = 1'b0;
          end
          default: ;
        endcase
        core_rst_o = need_rst;
        if (state_q == S_LP) begin
          pwr_state_o = to_rpt(tgt_q);
          busy_o      = 1'b0;
        end
      end
      S_UP, S_SETTLE: begin
        core_rst_o  = need_rst;
        pwr_state_o = to_rpt(tgt_q);
      end
      S_CLKON: begin
        clk_en_o    = 1'b1;
        core_rst_o  = need_rst;
        pwr_state_o = to_rpt(tgt_q);
      end
      S_RSTREL: begin
        clk_en_o    = 1'b1;
        pwr_state_o = to_rpt(tgt_q);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lp_pair_chk.sv
module lp_pair_chk
  import lp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] st0_i,
  input  logic [1:0] st1_i,
  input  logic       busy_i,
  output logic       err_o
);
  rpt_e s0, s1;
  logic legal;

  assign s0    = rpt_e'(st0_i);
  assign s1    = rpt_e'(st1_i);
  assign legal = (s0 != RPT_OFF) && ((s0 == s1) || (s1 == RPT_OFF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= 1'b0;
    else if (!busy_i) err_o <= !legal;
  end
endmodule

// File: rtl/lp_cluster_ctrl.sv
module lp_cluster_ctrl
  import lp_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] wfi_i,
  input  logic [1:0] wfe_i,
  input  logic [3:0] tgt_i,
  input  logic [3:0] clkmode_i,
  input  logic       l2_idle_i,
  input  logic [1:0] wake_i,
  output logic [1:0] clk_en_o,
  output logic [1:0] logic_pwr_o,
  output logic [1:0] logic_ret_o,
  output logic [1:0] l1_arr_pwr_o,
  output logic [1:0] l1_periph_pwr_o,
  output logic [1:0] core_rst_o,
  output logic [3:0] pwr_state_o,
  output logic [1:0] busy_o,
  output logic       pair_err_o
);
  localparam int unsigned NC = 2;
  localparam int unsigned FW = 2;

  for (genvar g = 0; g < NC; g++) begin : g_core
    logic peer_ok;
    assign peer_ok = l2_idle_i && wfi_i[NC-1-g];

    core_lp_seq #(.CORE_ID(g), .SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .wfi_i           (wfi_i[g]),
      .wfe_i           (wfe_i[g]),
      .tgt_i           (tgt_i[FW*g +: FW]),
      .clkmode_i       (clkmode_i[FW*g +: FW]),
      .peer_ok_i       (peer_ok),
      .wake_i          (wake_i[g]),
      .clk_en_o        (clk_en_o[g]),
      .logic_pwr_o     (logic_pwr_o[g]),
      .logic_ret_o     (logic_ret_o[g]),
      .l1_arr_pwr_o    (l1_arr_pwr_o[g]),
      .l1_periph_pwr_o (l1_periph_pwr_o[g]),
      .core_rst_o      (core_rst_o[g]),
      .pwr_state_o     (pwr_state_o[FW*g +: FW]),
      .busy_o          (busy_o[g])
    );
  end

  lp_pair_chk u_pair (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .st0_i  (pwr_state_o[1:0]),
    .st1_i  (pwr_state_o[3:2]),
    .busy_i (|busy_o),
    .err_o  (pair_err_o)
  );
endmodule

// File: rtl/lp_cluster_ctrl_sva.sv
module lp_cluster_ctrl_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] wfi_i,
  input logic [1:0] wfe_i,
  input logic [3:0] tgt_i,
  input logic [3:0] clkmode_i,
  input logic       l2_idle_i,
  input logic [1:0] wake_i,
  input logic [1:0] clk_en_o,
  input logic [1:0] logic_pwr_o,
  input logic [1:0] logic_ret_o,
  input logic [1:0] l1_arr_pwr_o,
  input logic [1:0] l1_periph_pwr_o,
  input logic [1:0] core_rst_o,
  input logic [3:0] pwr_state_o,
  input logic [1:0] busy_o,
  input logic       pair_err_o
);
  localparam logic [1:0] ON  = 2'd0;
  localparam logic [1:0] RET = 2'd2;
  localparam logic [1:0] OFF = 2'd3;

  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_gate_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(logic_pwr_o[g]) || $fell(l1_periph_pwr_o[g])) |-> !$past(clk_en_o[g]));

    p_lp_clk_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_state_o[2*g +: 2] != ON && !busy_o[g]) |-> !clk_en_o[g]);

    p_ret_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(logic_pwr_o[g] && logic_ret_o[g]));

    p_lp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_state_o[2*g +: 2] != ON && !busy_o[g] && !wake_i[g])
        |=> (pwr_state_o[2*g +: 2] == $past(pwr_state_o[2*g +: 2])));

    p_no_hop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(pwr_state_o[2*g +: 2]) != ON && pwr_state_o[2*g +: 2] != ON)
        |-> (pwr_state_o[2*g +: 2] == $past(pwr_state_o[2*g +: 2])));

    p_off_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_state_o[2*g +: 2] == OFF && !busy_o[g]) |-> core_rst_o[g]);

    p_ret_norst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_state_o[2*g +: 2] == RET) |-> !core_rst_o[g]);
  end

  p_core0_no_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o[1:0] != OFF);
endmodule

bind lp_cluster_ctrl lp_cluster_ctrl_sva i_sva (.*);

// File: tb/test_lp_cluster_ctrl.sv
module test_lp_cluster_ctrl;
  localparam int S = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] wfi_i = '0, wfe_i = '0, wake_i = '0;
  logic [3:0] tgt_i = '0, clkmode_i = '0;
  logic       l2_idle_i = 1'b0;
  logic [1:0] clk_en_o, logic_pwr_o, logic_ret_o, l1_arr_pwr_o, l1_periph_pwr_o;
  logic [1:0] core_rst_o, busy_o;
  logic [3:0] pwr_state_o;
  logic       pair_err_o;

  lp_cluster_ctrl #(.SETTLE_CYC(S)) i_lp_cluster_ctrl (.*);

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc = cyc + 1;

  typedef struct {
    int         cyc;
    int         core;
    logic [8:0] val;
    string      tag;
  } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;

  function automatic logic [8:0] actual(int c);
    if (c == 2) return {8'b0, pair_err_o};
    return {clk_en_o[c], logic_pwr_o[c], logic_ret_o[c], l1_arr_pwr_o[c],
            l1_periph_pwr_o[c], core_rst_o[c], pwr_state_o[2*c +: 2], busy_o[c]};
  endfunction

  // monitor: compares due expectations just before the next rising edge
  always @(negedge clk_i) begin
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc <= cyc) begin
        n_chk++;
        if (actual(q[i].core) !== q[i].val) begin
          n_fail++;
          $display("FAIL %s core%0d cyc %0d: actual %b expected %b",
                   q[i].tag, q[i].core, cyc, actual(q[i].core), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic push_core(int d, int c, bit ce, bit lp, bit lr, bit la, bit lpp,
                           bit rst, logic [1:0] st, bit bsy, string tag);
    exp_t e;
    e.cyc = cyc + d; e.core = c; e.tag = tag;
    e.val = {ce, lp, lr, la, lpp, rst, st, bsy};
    q.push_back(e);
  endtask

  task automatic exp_on(int d, int c, bit ce, string tag);
    push_core(d, c, ce, 1, 0, 1, 1, 0, 2'd0, 0, tag);
  endtask

  task automatic push_pair(int d, bit err, string tag);
    exp_t e;
    e.cyc = cyc + d; e.core = 2; e.tag = tag; e.val = {8'b0, err};
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R13 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R13 reset state
    exp_on(0, 0, 1, "R13");
    exp_on(0, 1, 1, "R13");
    push_pair(0, 0, "R13");

    // R3 wait-for-event never deepens
    step(1);
    wfe_i = 2'b01; tgt_i = 4'b0001; clkmode_i = 4'b0010; l2_idle_i = 1; wfi_i = 2'b10;
    exp_on(0, 0, 0, "R3");
    exp_on(3, 0, 0, "R3");
    exp_on(0, 1, 0, "R2");
    step(4);
    wfe_i = 0; wfi_i = 0;
    exp_on(0, 0, 1, "R3");

    // R2 non-auto mode keeps core on
    step(1);
    clkmode_i = 4'b0000; tgt_i = 4'b0010; wfi_i = 2'b11;
    exp_on(0, 0, 0, "R2");
    exp_on(3, 0, 0, "R2");
    step(4);
    wfi_i = 0;
    exp_on(0, 0, 1, "R2");

    // R4 entry blocked without idle cache or sibling standby
    step(1);
    clkmode_i = 4'b0010; tgt_i = 4'b0001; l2_idle_i = 0; wfi_i = 2'b11;
    exp_on(3, 0, 0, "R4");
    step(4);
    l2_idle_i = 1; wfi_i = 2'b01;
    exp_on(3, 0, 0, "R4");
    step(4);
    wfi_i = 0;
    exp_on(0, 0, 1, "R4");

    // R5 core 0 treats full-off code as on
    step(1);
    tgt_i = 4'b0011; wfi_i = 2'b01;
    exp_on(3, 0, 0, "R5");
    exp_on(3, 0, 0, "R1");
    step(4);
    wfi_i = 0; tgt_i = 0;
    exp_on(0, 0, 1, "R5");

    // retention on core 0, sibling on
    step(1);
    clkmode_i = 4'b0010; tgt_i = 4'b0010; l2_idle_i = 1; wfi_i = 2'b11;
    push_core(1, 0, 0, 1, 0, 1, 1, 0, 2'd0, 1, "R7");
    push_core(2, 0, 0, 0, 1, 1, 0, 0, 2'd0, 1, "R7");
    push_core(3, 0, 0, 0, 1, 1, 0, 0, 2'd2, 0, "R6");
    push_core(3, 0, 0, 0, 1, 1, 0, 0, 2'd2, 0, "R1");
    push_pair(4, 1, "R12");
    step(5);
    tgt_i[1:0] = 2'd3; clkmode_i[1:0] = 2'd0; wfi_i[0] = 0;
    push_core(2, 0, 0, 0, 1, 1, 0, 0, 2'd2, 0, "R9");
    push_core(3, 0, 0, 0, 1, 1, 0, 0, 2'd2, 0, "R8");
    step(3);
    wake_i = 2'b01;
    push_core(1, 0, 0, 1, 0, 1, 1, 0, 2'd2, 1, "R10");
    step(1);
    wake_i = 0;
    push_core(S,     0, 0, 1, 0, 1, 1, 0, 2'd2, 1, "R10");
    push_core(S + 1, 0, 1, 1, 0, 1, 1, 0, 2'd2, 1, "R10");
    push_core(S + 2, 0, 1, 1, 0, 1, 1, 0, 2'd0, 0, "R8");
    step(S + 3);
    wfi_i = 0; tgt_i = 0; clkmode_i = 0;

    // full-off on core 1 with sibling running
    step(1);
    clkmode_i = 4'b1000; tgt_i = 4'b1100; wfi_i = 2'b10;
    push_core(1, 1, 0, 1, 0, 1, 1, 0, 2'd0, 1, "R7");
    push_core(2, 1, 0, 0, 0, 0, 0, 1, 2'd0, 1, "R11");
    push_core(3, 1, 0, 0, 0, 0, 0, 1, 2'd3, 0, "R5");
    push_pair(4, 0, "R12");
    step(4);
    wfi_i = 0; wake_i = 2'b10;
    push_core(1, 1, 0, 1, 0, 1, 1, 1, 2'd3, 1, "R11");
    step(1);
    wake_i = 0;
    push_core(S + 1, 1, 1, 1, 0, 1, 1, 1, 2'd3, 1, "R11");
    push_core(S + 2, 1, 1, 1, 0, 1, 1, 0, 2'd3, 1, "R11");
    push_core(S + 3, 1, 1, 1, 0, 1, 1, 0, 2'd0, 0, "R11");
    step(S + 4);
    tgt_i = 0; clkmode_i = 0;

    // INACT on core 0 with core 1 on: forbidden pair
    step(1);
    clkmode_i = 4'b0010; tgt_i = 4'b0001; l2_idle_i = 1; wfi_i = 2'b11;
    push_core(3, 0, 0, 1, 0, 1, 1, 0, 2'd1, 0, "R6");
    push_pair(4, 1, "R12");
    step(4);
    wfi_i = 0; wake_i = 2'b01;
    step(1);
    wake_i = 0;
    push_core(S + 2, 0, 1, 1, 0, 1, 1, 0, 2'd0, 0, "R10");
    push_pair(S + 3, 0, "R12");
    step(S + 4);

    // both INACT: coherent pair
    clkmode_i = 4'b1010; tgt_i = 4'b0101; wfi_i = 2'b11;
    push_core(3, 0, 0, 1, 0, 1, 1, 0, 2'd1, 0, "R4");
    push_core(3, 1, 0, 1, 0, 1, 1, 0, 2'd1, 0, "R4");
    push_pair(4, 0, "R12");
    step(4);
    wfi_i = 0; wake_i = 2'b11;
    step(1);
    wake_i = 0;
    exp_on(S + 2, 0, 1, "R10");
    exp_on(S + 2, 1, 1, "R10");
    step(S + 6);

    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R13 scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule